// File: doc/BRIEF.md
# GPIO Port Pin-Interrupt Controller

This block produces the interrupt for one general purpose IO port of eight pins. Each pin has a 2-bit interrupt mode and an enable bit. A pin can be off, it can fire while its level is low, it can fire while its level is high, or it can fire while its level differs from the value software last read from the port. The per-pin conditions are ORed into one level-sensitive port interrupt, and a global-enable input gates that interrupt.

Software configures the block through a small register bus. Reading the port data location returns the synchronized pin levels and also loads a per-pin read latch with them. The change mode compares each pin against that latch. This is a level comparison, not an edge detector. A pin in change mode therefore holds the interrupt asserted until the port is read and the latch matches the pin again. If the port is never read, the pin behaves as a fixed level mode, chosen by the stale latch value.

Top module: `gpio_pin_irq`

## Requirements
- R1: After reset, both mode registers and the enable register read 0x00, and `irq_o` and `pend_o` are 0.
- R2: Address 1 holds mode-low bits, address 2 holds mode-high bits and address 3 holds enable bits. Each of these locations returns the last value written to it. A write to address 0 changes nothing.
- R3: A pin whose mode {high bit, low bit} is 00 never sets its `pend_o` bit, even when its enable bit is 1.
- R4: In mode 01 an enabled pin sets its `pend_o` bit while its synchronized level is 0.
- R5: In mode 10 an enabled pin sets its `pend_o` bit while its synchronized level is 1.
- R6: In mode 11 an enabled pin sets its `pend_o` bit while its synchronized level differs from its read-latch bit. After a read that makes the latch equal the pin, the bit clears on the next cycle.
- R7: The read latch loads only on a read of address 0. Without such a read, a mode-11 condition stays asserted for any number of cycles.
- R8: Pin inputs pass through two flops. A read of address 0 returns the levels that `pin_i` had two clock edges earlier, and the latch loads those same levels.
- R9: A pin whose enable bit is 0 never sets its `pend_o` bit.
- R10: `irq_o` is high exactly when `gie_i` is 1 and at least one `pend_o` bit is set. `rdata_o` is 0 when `rd_i` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pin_i | input | 8 | Asynchronous pin levels |
| addr_i | input | 2 | Register address: 0 data, 1 mode-low, 2 mode-high, 3 enable |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, valid in the cycle `rd_i` is high |
| gie_i | input | 1 | Global interrupt enable |
| pend_o | output | 8 | Per-pin interrupt condition |
| irq_o | output | 1 | Port interrupt, level-sensitive |

## Verification
The assertions assume that `wr_i` and `rd_i` are never high in the same cycle, and that the input buses are stable around the clock edge. The bench drives every input one time unit after the rising edge and never raises both strobes together. The two-stage delay assertion counts cycles from reset. It therefore assumes that `pin_i` is defined from the first cycle after reset. The bench holds the pins at a known value throughout reset.

// File: rtl/gpio_pin_irq.sv
module gpio_pin_irq #(
  parameter int PINS = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PINS-1:0] pin_i,
  input  logic [1:0]      addr_i,
  input  logic            wr_i,
  input  logic            rd_i,
  input  logic [PINS-1:0] wdata_i,
  output logic [PINS-1:0] rdata_o,
  input  logic            gie_i,
  output logic [PINS-1:0] pend_o,
  output logic            irq_o
);
  localparam logic [1:0] A_DATA = 2'd0;
  localparam logic [1:0] A_MLO  = 2'd1;
  localparam logic [1:0] A_MHI  = 2'd2;
  localparam logic [1:0] A_EN   = 2'd3;

  logic [SYNC_STAGES-1:0][PINS-1:0] sync_q;
  logic [PINS-1:0] pin_sync, rd_latch, mode_lo_q, mode_hi_q, en_q;
  logic data_rd;

  assign pin_sync = sync_q[SYNC_STAGES-1];
  assign data_rd  = rd_i && (addr_i == A_DATA);

  always_ff @(posedge clk) begin
    if (!rst_n) sync_q[0] <= '0;
    else        sync_q[0] <= pin_i;
  end

  for (genvar s = 1; s < SYNC_STAGES; s++) begin : g_sync
    always_ff @(posedge clk) begin
      if (!rst_n) sync_q[s] <= '0;
      else        sync_q[s] <= sync_q[s-1];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_lo_q <= '0;
      mode_hi_q <= '0;
      en_q      <= '0;
      rd_latch  <= '0;
    end else begin
      if (wr_i && addr_i == A_MLO) mode_lo_q <= wdata_i;
      if (wr_i && addr_i == A_MHI) mode_hi_q <= wdata_i;
      if (wr_i && addr_i == A_EN)  en_q      <= wdata_i;
      if (data_rd)                 rd_latch  <= pin_sync;
    end
  end

  for (genvar i = 0; i < PINS; i++) begin : g_pin
    logic hit;
    always_comb begin
      unique case ({mode_hi_q[i], mode_lo_q[i]})
        2'b01:   hit = !pin_sync[i];
        2'b10:   hit = pin_sync[i];
        2'b11:   hit = pin_sync[i] ^ rd_latch[i];
        default: hit = 1'b0;
      endcase
    end
    assign pend_o[i] = hit && en_q[i];
  end

  assign irq_o = gie_i && (|pend_o);

  always_comb begin
    rdata_o = '0;
    if (rd_i) begin
      unique case (addr_i)
        A_DATA:  rdata_o = pin_sync;
        A_MLO:   rdata_o = mode_lo_q;
        A_MHI:   rdata_o = mode_hi_q;
        default: rdata_o = en_q;
      endcase
    end
  end
endmodule

// File: rtl/gpio_pin_irq_chk.sv
module gpio_pin_irq_chk #(
  parameter int PINS = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic [PINS-1:0] pin_i,
  input logic [1:0]      addr_i,
  input logic            wr_i,
  input logic            rd_i,
  input logic            gie_i,
  input logic [PINS-1:0] rdata_o,
  input logic [PINS-1:0] pend_o,
  input logic            irq_o,
  input logic [PINS-1:0] pin_sync,
  input logic [PINS-1:0] rd_latch,
  input logic [PINS-1:0] mode_lo_q,
  input logic [PINS-1:0] mode_hi_q,
  input logic [PINS-1:0] en_q
);
  logic [1:0] cyc;
  always_ff @(posedge clk) begin
    if (!rst_n) cyc <= '0;
    else if (cyc != 2'd3) cyc <= cyc + 2'd1;
  end

  p_disabled_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_o & ~(mode_lo_q | mode_hi_q)) == '0);

  p_enable_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_o & ~en_q) == '0);

  p_gie_gate_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !gie_i |-> !irq_o);

  p_latch_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc != 2'd0 && !(rd_i && addr_i == 2'd0)) |=> $stable(rd_latch));

  p_latch_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_i && addr_i == 2'd0) |=> rd_latch == $past(pin_sync));

  p_sync_delay_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc >= 2'd2) |-> pin_sync == $past(pin_i, 2));

  p_readback_en_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_i && addr_i == 2'd3) |-> rdata_o == en_q);

  p_idle_bus_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_i |-> rdata_o == '0);

  p_no_strobe_clash: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_i && wr_i));
endmodule

bind gpio_pin_irq gpio_pin_irq_chk #(.PINS(PINS)) u_chk (
  .clk(clk), .rst_n(rst_n), .pin_i(pin_i), .addr_i(addr_i), .wr_i(wr_i),
  .rd_i(rd_i), .gie_i(gie_i), .rdata_o(rdata_o), .pend_o(pend_o),
  .irq_o(irq_o), .pin_sync(pin_sync), .rd_latch(rd_latch),
  .mode_lo_q(mode_lo_q), .mode_hi_q(mode_hi_q), .en_q(en_q)
);

// File: tb/test_gpio_pin_irq.sv
`timescale 1ns/1ps
module test_gpio_pin_irq;
  logic clk = 0, rst_n = 0;
  logic [7:0] pin_i = '0, wdata_i = '0;
  logic [1:0] addr_i = '0;
  logic wr_i = 0, rd_i = 0, gie_i = 1;
  logic [7:0] rdata_o, pend_o;
  logic irq_o;
  int checks = 0, fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  gpio_pin_irq i_gpio_pin_irq (
    .clk(clk), .rst_n(rst_n), .pin_i(pin_i), .addr_i(addr_i), .wr_i(wr_i),
    .rd_i(rd_i), .wdata_i(wdata_i), .rdata_o(rdata_o), .gie_i(gie_i),
    .pend_o(pend_o), .irq_o(irq_o)
  );

  // behavioural reference
  logic [7:0] m_s1 = '0, m_s2 = '0, m_lat = '0, m_lo = '0, m_hi = '0, m_en = '0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_s1 = '0; m_s2 = '0; m_lat = '0; m_lo = '0; m_hi = '0; m_en = '0;
    end else begin
      if (wr_i && addr_i == 1) m_lo = wdata_i;
      if (wr_i && addr_i == 2) m_hi = wdata_i;
      if (wr_i && addr_i == 3) m_en = wdata_i;
      if (rd_i && addr_i == 0) m_lat = m_s2;
      m_s2 = m_s1;
      m_s1 = pin_i;
    end
  end

  function automatic logic [7:0] exp_pend();
    logic [7:0] r = '0;
    for (int i = 0; i < 8; i++) begin
      int md = m_hi[i] * 2 + m_lo[i];
      bit h = (md == 1) ? !m_s2[i] : (md == 2) ? m_s2[i] : (md == 3) ? (m_s2[i] != m_lat[i]) : 1'b0;
      r[i] = h && m_en[i];
    end
    return r;
  endfunction

  function automatic logic [7:0] exp_rdata();
    if (!rd_i) return '0;
    case (addr_i)
      2'd0: return m_s2;
      2'd1: return m_lo;
      2'd2: return m_hi;
      default: return m_en;
    endcase
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      check("R10 model pend", pend_o, exp_pend());
      check("R10 model irq", irq_o, gie_i && (exp_pend() != 0));
      check("R2 model rdata", rdata_o, exp_rdata());
    end
  end

  task automatic step(int n = 1);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    addr_i = a; wdata_i = d; wr_i = 1;
    step();
    wr_i = 0;
  endtask

  task automatic rd(logic [1:0] a, output logic [7:0] d);
    addr_i = a; rd_i = 1;
    @(negedge clk); d = rdata_o;
    step();
    rd_i = 0;
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #100000;
    checks++; fails++;
    $display("FAIL watchdog expired");
    done = 1;
    report();
  end

  initial begin
    logic [7:0] d;
    step(3);
    rst_n = 1;
    step();
    // R1 reset state
    check("R1 irq", irq_o, 0);
    check("R1 pend", pend_o, 0);
    rd(1, d); check("R1 mode-low", d, 0);
    rd(2, d); check("R1 mode-high", d, 0);
    rd(3, d); check("R1 enable", d, 0);
    // R2 readback, addr 0 write ignored
    wr(1, 8'hA5); wr(2, 8'h3C); wr(3, 8'h0F); wr(0, 8'hFF);
    rd(1, d); check("R2 mode-low", d, 8'hA5);
    rd(2, d); check("R2 mode-high", d, 8'h3C);
    rd(3, d); check("R2 enable", d, 8'h0F);
    // R3 mode 00 with enable on
    wr(1, 0); wr(2, 0); wr(3, 8'hFF);
    pin_i = 8'h55; step(3);
    check("R3 pend", pend_o, 0);
    pin_i = 8'hAA; step(3);
    check("R3 pend", pend_o, 0);
    // R4 mode 01 level low on pin 1
    wr(1, 8'h02);
    pin_i = 8'h00; step(3);
    check("R4 low", pend_o, 8'h02);
    pin_i = 8'h02; step(3);
    check("R4 high", pend_o, 0);
    // R5 mode 10 level high on pin 4
    wr(1, 0); wr(2, 8'h10);
    pin_i = 8'h10; step(3);
    check("R5 high", pend_o, 8'h10);
    // R10 gie gating
    gie_i = 0; step();
    check("R10 gie off", irq_o, 0);
    gie_i = 1; step();
    check("R10 gie on", irq_o, 1);
    // R9 enable off
    wr(3, 8'hEF); step();
    check("R9 enable off", pend_o, 0);
    // R8 sync delay
    wr(2, 0); wr(3, 8'hFF);
    pin_i = 8'h3C; step();
    rd(0, d); check("R8 one edge", d, 8'h10);
    rd(0, d); check("R8 two edges", d, 8'h3C);
    // R6/R7 change mode on pin 0, latch now 3C
    wr(1, 8'h01); wr(2, 8'h01); wr(3, 8'h01);
    pin_i = 8'h3D; step(3);
    check("R6 differs", irq_o, 1);
    step(40);
    check("R7 held without read", irq_o, 1);
    rd(0, d);
    check("R6 cleared after read", irq_o, 0);
    pin_i = 8'h3C; step(3);
    check("R6 latch 1 acts as low", irq_o, 1);
    rd(0, d);
    check("R6 cleared again", irq_o, 0);
    // mixed traffic against the model
    for (int k = 0; k < 600; k++) begin
      int op = $urandom_range(0, 9);
      pin_i = 8'($urandom);
      if (op == 0) wr(2'($urandom), 8'($urandom));
      else if (op < 3) rd(2'($urandom), d);
      else begin
        gie_i = ($urandom_range(0, 7) != 0);
        step();
      end
    end
    done = 1;
    report();
  end
endmodule